// File: doc/BRIEF.md
# HMAC Key Store with Pad Generation

This block keeps a keyed-hash secret of up to 64 bytes as eight 64-bit words. Software writes and reads the words over a plain register interface with a write strobe, a word index and a combinational read port. A hash-mode input chooses between SHA-1, SHA-256 and MD5. The first two keep key bytes big-endian. MD5 is little-endian, so in that mode the block reverses the four bytes inside each 32-bit half of a word as the word is stored. It applies the same reversal when the word is read back, so software sees the value it wrote.

A hash core asks for a padded key block with a one-cycle request and a select bit. The block then streams the inner-pad block (every stored byte XOR 0x36) or the outer-pad block (every stored byte XOR 0x5C) as eight words, one per cycle, each marked by a valid strobe. Software takes no part in making the pads. A synchronous clear zeroes the whole key.

Top module: `hmac_key_store`

## Requirements
- R1: After reset every key word reads as zero, pad_valid and pad_last are low, and pad_data is zero.
- R2: In mode 0 (SHA-1) and mode 1 (SHA-256), a word written at index i is stored unchanged and reads back unchanged at index i.
- R3: In mode 2 (MD5), a write stores the word with the byte order reversed inside each 32-bit half: bits [31:0] and [63:32] are each reversed on their own. A read in mode 2 applies the same reversal, so it returns the value that was written.
- R4: The reversal follows the mode at the moment of access. A word written in mode 2 and read in mode 0 shows its two halves byte-reversed. A word written in mode 0 and read in mode 2 shows the same effect.
- R5: Mode 3 is reserved and behaves as big-endian (no reversal) on both the write path and the read path.
- R6: A high clr at a clock edge sets all eight words to zero. It takes priority over a write in the same cycle, and that write is lost.
- R7: A pad_req accepted while no burst is running makes pad_valid high for exactly eight consecutive cycles, starting in the cycle after acceptance. The burst carries words 0 to 7 in order. pad_last is high only with the eighth word. pad_data is zero whenever pad_valid is low.
- R8: With pad_sel=0 at acceptance, each byte of a burst word is the stored key byte XOR 0x36. With pad_sel=1, it is the stored key byte XOR 0x5C. The bytes are taken in stored order, which is the MD5-reversed order for words written in mode 2.
- R9: A pad_req raised while a burst is running is ignored. The running burst keeps the select it was accepted with and keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous key clear, takes priority over a write |
| hash_mode | input | 2 | 0 SHA-1, 1 SHA-256, 2 MD5, 3 reserved (big-endian) |
| wr_en | input | 1 | Key word write strobe |
| wr_addr | input | 3 | Index of the word to write |
| wr_data | input | 64 | Word to write, in software byte order |
| rd_addr | input | 3 | Index of the word to read |
| rd_data | output | 64 | Addressed word, in software byte order |
| pad_req | input | 1 | Request for one pad burst |
| pad_sel | input | 1 | 0 selects the inner pad, 1 selects the outer pad |
| pad_valid | output | 1 | Marks each word of a burst |
| pad_last | output | 1 | Marks the eighth word of a burst |
| pad_data | output | 64 | Padded key word, zero when no burst is running |

## Verification
The bench builds the block with its default parameters: eight 64-bit words split into 32-bit swap lanes. With these values the three-bit index reaches every word, and a single burst reaches every sequencer position, including the last-word boundary. Both swap lanes receive distinct byte patterns. The model checks that the MD5 reversal stays inside each 32-bit half and never moves bytes across the whole 64-bit word.

// File: rtl/hks_pkg.sv
// Shared types and constants for the HMAC key store.
// Assumes a two-bit hash-mode code. Only the MD5 code selects
// little-endian byte order.
package hks_pkg;

    typedef enum logic [1:0] {
        HASH_SHA1   = 2'd0,
        HASH_SHA256 = 2'd1,
        HASH_MD5    = 2'd2,
        HASH_RSVD   = 2'd3
    } hash_mode_e;

    localparam logic [7:0] INNER_PAD_BYTE = 8'h36;
    localparam logic [7:0] OUTER_PAD_BYTE = 8'h5C;

    // True when the mode needs little-endian key bytes
    function automatic logic mode_is_le(input logic [1:0] m);
        return m == HASH_MD5;
    endfunction

endpackage

// File: rtl/hks_byte_swap.sv
// Conditional byte reversal inside each LANE_W-bit lane of a word.
// Assumes WORD_W is a multiple of LANE_W and LANE_W is a multiple of 8.
// The logic is purely combinational. The output passes the input
// unchanged when en is low.
module hks_byte_swap #(
    parameter int WORD_W = 64,
    parameter int LANE_W = 32
) (
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int LANES      = WORD_W / LANE_W;
    localparam int LANE_BYTES = LANE_W / 8;

    logic [WORD_W-1:0] swapped;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
            assign swapped[l*LANE_W + 8*b +: 8] =
                din[l*LANE_W + 8*(LANE_BYTES-1-b) +: 8];
        end
    end

    // Choose the reversed or straight form of the word
    always_comb dout = en ? swapped : din;

endmodule

// File: rtl/hks_key_bank.sv
// Key storage: WORDS registers of WORD_W bits, each with its own
// write enable.
// Assumes write data arrives already in stored byte order. A clear
// beats a write. There are two combinational read ports: one for
// software, one for the pad sequencer.
module hks_key_bank #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    input  logic [AW-1:0]     pad_addr,
    output logic [WORD_W-1:0] pad_word
);
    logic [WORD_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Hold one key word: reset and clear zero it, then a matching write loads it
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                mem[w] <= '0;
            else if (wr_en && wr_addr == AW'(w))
                mem[w] <= wr_word;
        end
    end

    // Software read port
    always_comb rd_word = mem[rd_addr];

    // Pad sequencer read port
    always_comb pad_word = mem[pad_addr];

endmodule

// File: rtl/hks_pad_seq.sv
// Pad burst sequencer. It accepts a request only when idle, latches
// the pad select, and walks the word index from 0 to WORDS-1, one
// step per cycle.
// Assumes requests are single-cycle pulses. Requests made during a
// burst are dropped.
module hks_pad_seq #(
    parameter int WORDS = 8,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          sel,
    output logic          busy,
    output logic          last,
    output logic          sel_q,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    // Burst state: start on an idle request, advance, stop after the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            sel_q <= 1'b0;
        end else if (busy) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end else if (req) begin
            busy  <= 1'b1;
            idx   <= '0;
            sel_q <= sel;
        end
    end

    // Flag the final word of a burst
    always_comb last = busy && (idx == LAST_IDX);

endmodule

// File: rtl/hmac_key_store.sv
// HMAC key store top. It converts byte order between software and
// storage according to the hash mode, and streams inner or outer pad
// blocks on request.
// Assumes the mode is steady around each access. The reversal follows
// the mode at the moment of each write or read.
module hmac_key_store
    import hks_pkg::*;
#(
    parameter  int KEY_WORDS = 8,
    parameter  int WORD_W    = 64,
    parameter  int LANE_W    = 32,
    localparam int ADDR_W    = $clog2(KEY_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [1:0]        hash_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pad_req,
    input  logic              pad_sel,
    output logic              pad_valid,
    output logic              pad_last,
    output logic [WORD_W-1:0] pad_data
);
    localparam int NBYTES = WORD_W / 8;

    logic              little_end;
    logic [WORD_W-1:0] wr_stored;
    logic [WORD_W-1:0] rd_stored;
    logic [WORD_W-1:0] pad_word;
    logic              seq_busy;
    logic              seq_last;
    logic              seq_sel;
    logic [ADDR_W-1:0] seq_idx;
    logic [7:0]        pad_byte;

    // Decide the byte order from the mode
    always_comb little_end = mode_is_le(hash_mode);

    hks_byte_swap #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_swap_in (
        .en   (little_end),
        .din  (wr_data),
        .dout (wr_stored)
    );

    hks_key_bank #(.WORDS(KEY_WORDS), .WORD_W(WORD_W), .AW(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (wr_stored),
        .rd_addr  (rd_addr),
        .rd_word  (rd_stored),
        .pad_addr (seq_idx),
        .pad_word (pad_word)
    );

    hks_byte_swap #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_swap_out (
        .en   (little_end),
        .din  (rd_stored),
        .dout (rd_data)
    );

    hks_pad_seq #(.WORDS(KEY_WORDS), .AW(ADDR_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pad_req),
        .sel   (pad_sel),
        .busy  (seq_busy),
        .last  (seq_last),
        .sel_q (seq_sel),
        .idx   (seq_idx)
    );

    // Pick the pad constant latched at acceptance
    always_comb pad_byte = seq_sel ? OUTER_PAD_BYTE : INNER_PAD_BYTE;

    for (genvar b = 0; b < NBYTES; b++) begin : g_pad
        // XOR one stored byte with the pad constant, zero outside a burst
        always_comb pad_data[8*b +: 8] = seq_busy ? (pad_word[8*b +: 8] ^ pad_byte) : 8'h00;
    end

    // Burst strobes
    always_comb begin
        pad_valid = seq_busy;
        pad_last  = seq_last;
    end

endmodule

// File: rtl/hks_checker.sv
// Protocol checker for hmac_key_store, attached with bind.
// Assumes synchronous active-low reset. It counts burst length with
// its own counter.
module hks_checker #(
    parameter int KEY_WORDS = 8,
    parameter int WORD_W    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic [WORD_W-1:0] rd_data,
    input logic              pad_req,
    input logic              pad_valid,
    input logic              pad_last,
    input logic [WORD_W-1:0] pad_data
);
    int unsigned beat_cnt;

    // Count the valid beats of the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || !pad_valid)
            beat_cnt <= pad_valid ? 1 : 0;
        else
            beat_cnt <= beat_cnt + 1;
    end

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> rd_data == '0);

    assert_burst_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_req && !pad_valid) |=> pad_valid);

    assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_last |=> !pad_valid);

    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_last |-> pad_valid);

    assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid && !pad_last) |-> beat_cnt < KEY_WORDS - 1);

    assert_idle_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_valid |-> pad_data == '0);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid && !pad_last) |=> pad_valid);

endmodule

bind hmac_key_store hks_checker #(.KEY_WORDS(KEY_WORDS), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .rd_data   (rd_data),
    .pad_req   (pad_req),
    .pad_valid (pad_valid),
    .pad_last  (pad_last),
    .pad_data  (pad_data)
);

// File: tb/sim_hmac_key_store.sv
module sim_hmac_key_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  hash_mode = 2'd0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        pad_req = 1'b0;
    logic        pad_sel = 1'b0;
    logic        pad_valid;
    logic        pad_last;
    logic [63:0] pad_data;

    int vectors = 0;
    int misses  = 0;
    string cur_req = "R1";

    // reference state
    logic [63:0] mkey [8];
    bit          mbusy;
    int          midx;
    bit          msel;

    always #5 clk = ~clk;

    hmac_key_store u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hash_mode(hash_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_req(pad_req), .pad_sel(pad_sel),
        .pad_valid(pad_valid), .pad_last(pad_last), .pad_data(pad_data)
    );

    function automatic logic [63:0] lane_rev(input logic [63:0] v);
        logic [63:0] r;
        for (int h = 0; h < 2; h++)
            for (int k = 0; k < 4; k++)
                r[h*32 + 8*k +: 8] = v[h*32 + 8*(3-k) +: 8];
        return r;
    endfunction

    // model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mkey[i] = '0;
            mbusy = 0; midx = 0; msel = 0;
        end else begin
            if (clr) begin
                for (int i = 0; i < 8; i++) mkey[i] = '0;
            end else if (wr_en) begin
                mkey[wr_addr] = (hash_mode == 2'd2) ? lane_rev(wr_data) : wr_data;
            end
            if (mbusy) begin
                if (midx == 7) begin mbusy = 0; midx = 0; end
                else midx++;
            end else if (pad_req) begin
                mbusy = 1; midx = 0; msel = pad_sel;
            end
        end
    end

    task automatic compare();
        logic [63:0] e_rd, e_pd;
        bit e_v, e_l;
        e_rd = (hash_mode == 2'd2) ? lane_rev(mkey[rd_addr]) : mkey[rd_addr];
        e_v  = mbusy;
        e_l  = mbusy && midx == 7;
        e_pd = '0;
        if (mbusy) e_pd = mkey[midx] ^ {8{msel ? 8'h5C : 8'h36}};
        vectors++;
        if (rd_data !== e_rd || pad_valid !== e_v || pad_last !== e_l || pad_data !== e_pd) begin
            misses++;
            $display("FAIL %s: rd=%h v=%b l=%b pd=%h, expected rd=%h v=%b l=%b pd=%h",
                     cur_req, rd_data, pad_valid, pad_last, pad_data, e_rd, e_v, e_l, e_pd);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        wr_en = 0; clr = 0; pad_req = 0;
    endtask

    task automatic write_word(input logic [1:0] m, input int a, input logic [63:0] d);
        hash_mode = m; wr_en = 1; wr_addr = 3'(a); wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic read_all(input logic [1:0] m);
        hash_mode = m;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            step();
        end
    endtask

    task automatic burst(input bit s, input bit poke);
        pad_req = 1; pad_sel = s;
        step();
        pad_req = 0;
        for (int k = 0; k < 9; k++) begin
            if (poke && k == 3) begin pad_req = 1; pad_sel = ~s; end
            else pad_req = 0;
            step();
        end
        pad_req = 0;
        step();
    endtask

    initial begin
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        read_all(2'd0);
        step();

        cur_req = "R2";
        for (int a = 0; a < 8; a++)
            write_word(2'd0, a, {8'h10 + 8'(a), 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76, 8'h87 ^ 8'(a)});
        read_all(2'd0);
        write_word(2'd1, 5, 64'hDEAD_BEEF_0123_4567);
        read_all(2'd1);

        cur_req = "R3";
        write_word(2'd2, 1, 64'h0102_0304_A1B2_C3D4);
        write_word(2'd2, 6, 64'hFFEE_DDCC_1122_3344);
        read_all(2'd2);

        cur_req = "R4";
        read_all(2'd0);
        read_all(2'd1);

        cur_req = "R5";
        write_word(2'd3, 2, 64'h8899_AABB_CCDD_EEFF);
        read_all(2'd3);

        cur_req = "R8";
        hash_mode = 2'd0;
        burst(1'b0, 1'b0);
        burst(1'b1, 1'b0);
        hash_mode = 2'd2;
        burst(1'b0, 1'b0);

        cur_req = "R7";
        pad_req = 1; pad_sel = 1;
        step();
        pad_req = 0;
        repeat (3) step();
        write_word(2'd0, 4, 64'h0F0F_0F0F_F0F0_F0F0);
        repeat (6) step();

        cur_req = "R9";
        burst(1'b0, 1'b1);
        burst(1'b1, 1'b1);

        cur_req = "R6";
        clr = 1; wr_en = 1; wr_addr = 3'd3; wr_data = 64'h1234_5678_9ABC_DEF0;
        hash_mode = 2'd0;
        step();
        clr = 0; wr_en = 0;
        read_all(2'd0);
        burst(1'b1, 1'b0);

        cur_req = "R1";
        write_word(2'd0, 7, 64'hCAFE_F00D_CAFE_F00D);
        rst_n = 0;
        step();
        rst_n = 1;
        read_all(2'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule